// File: doc/BRIEF.md
# Video Timing Mode Table Matcher

This block takes one set of measured input timing and finds the preset video mode it belongs to. The measurement gives the horizontal frequency in steps of 0.1 kHz, the vertical frequency in steps of 0.1 Hz, and the two sync polarities. A one-cycle strobe marks a new measurement. The block then steps through a 16-entry constant mode table, checking one entry per clock. It reports the chosen entry's index together with that entry's active size, total size and start positions.

An entry is an exact match when it accepts the measured polarity pair and both frequencies fall inside that entry's own tolerances. When no entry is an exact match, the block picks the nearest entry among those that accept the polarity and marks the result as approximate.

Once a mode is chosen, the block keeps watching new measurements. A change in polarity, or a horizontal frequency that has moved far enough, raises a one-cycle change pulse and starts a new search at once. Smaller drifts are ignored.

The controller is a four-state machine:
- **IDLE**: waits for a strobe, then goes to SCAN (transition *capture*).
- **SCAN**: checks table entries 0 to 15, one per clock, then goes to FIN (transition *last entry*).
- **FIN**: loads the result. It goes to LOCK when an entry was found (transition *lock*), or back to IDLE when none was (transition *no mode*).
- **LOCK**: checks each new strobe against the locked measurement. It goes to SCAN only on a significant change (transition *relock*).

Top module: `vmode_matcher`

## Requirements
- R1: While reset is held, and after its release until the first result, every output is zero. This includes `res_valid` and `chg_pulse`.
- R2: A table entry is an exact match when all three of these hold:
  - bit {hpol,vpol} of its polarity mask is set (bit 0 = both negative, bit 1 = h negative / v positive, bit 2 = h positive / v negative, bit 3 = both positive; a pol input of 1 means positive);
  - |meas_hfreq − nominal h| ≤ h tolerance;
  - |meas_vfreq − nominal v| ≤ v tolerance.

  The block then reports that entry's parameters with `res_exact`=1 and `res_found`=1.
- R3: When several entries match exactly, the one with the lowest index is reported. Entries 0, 1 and 2 share the same frequencies and the same accepted polarity.
- R4: When no entry matches exactly but at least one accepts the polarity, the block reports the accepting entry with the smallest |Δh|+|Δv|. Ties go to the lowest index. It sets `res_exact`=0 and `res_found`=1.
- R5: When no entry accepts the polarity, the result has `res_found`=0, `res_exact`=0, index 0 and all size and position fields 0. The block then returns to IDLE.
- R6: When a strobe is sampled at clock edge k, and the block was in IDLE or the strobe caused a relock, `res_valid` is high for exactly one cycle, following edge k+17. The result outputs change only at that edge.
- R7: A strobe that arrives while a search is running has no effect on the search or on its result.
- R8: While locked, a strobe with the same polarities and |meas_hfreq − locked hfreq| ≤ 2 × the locked entry's h tolerance changes no output and starts no search.
- R9: While locked, a strobe with a different polarity, or with an h change greater than twice the tolerance, raises `chg_pulse` for one cycle following its sampling edge. The same edge starts a search of that measurement.
- R10: After a no-mode result, the next strobe starts a search without raising `chg_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| meas_valid | input | 1 | One-cycle strobe for a new measurement |
| meas_hfreq | input | 12 | Horizontal frequency, 0.1 kHz units |
| meas_vfreq | input | 12 | Vertical frequency, 0.1 Hz units |
| meas_hpol | input | 1 | Hsync polarity, 1 = positive |
| meas_vpol | input | 1 | Vsync polarity, 1 = positive |
| res_valid | output | 1 | One-cycle pulse when a result is loaded |
| res_index | output | 4 | Chosen table entry |
| res_exact | output | 1 | Result is within tolerance |
| res_found | output | 1 | Some entry accepted the polarity |
| res_hact | output | 12 | Active width |
| res_vact | output | 12 | Active height |
| res_htotal | output | 12 | Horizontal total |
| res_vtotal | output | 12 | Vertical total |
| res_hstart | output | 12 | Horizontal start position |
| res_vstart | output | 12 | Vertical start position |
| chg_pulse | output | 1 | One-cycle request for re-detection |

## Verification
The change monitor and the search launcher act on the same strobe edge. A significant change in LOCK must both pulse `chg_pulse` and capture the new measurement for a fresh search.

The bench provokes this in three ways:
- a horizontal jump while locked;
- a pure polarity flip while locked;
- a step one unit past twice the tolerance, set beside a step exactly at the limit.

The reference model checks, on every clock, that the pulse appears in the cycle after the strobe. It also checks that the matching result follows 17 edges after that strobe. A second strobe issued mid-search confirms that launching is suppressed while the scanner is busy.

// File: rtl/vmode_pkg.sv
package vmode_pkg;

    localparam int FW = 12;
    localparam int DW = 12;
    localparam int NE = 16;

    typedef struct packed {
        logic [3:0]    pol_mask;
        logic [FW-1:0] hf;
        logic [FW-1:0] vf;
        logic [FW-1:0] htol;
        logic [FW-1:0] vtol;
        logic [DW-1:0] hact;
        logic [DW-1:0] vact;
        logic [DW-1:0] htot;
        logic [DW-1:0] vtot;
        logic [DW-1:0] hst;
        logic [DW-1:0] vst;
    } mode_t;

    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIN, ST_LOCK} st_t;

    function automatic mode_t mk(input int m, input int h, input int v,
                                 input int ht, input int vt,
                                 input int ha, input int va,
                                 input int tt, input int vv,
                                 input int hs, input int vs);
        mode_t e;
        e.pol_mask = 4'(m);
        e.hf   = FW'(h);
        e.vf   = FW'(v);
        e.htol = FW'(ht);
        e.vtol = FW'(vt);
        e.hact = DW'(ha);
        e.vact = DW'(va);
        e.htot = DW'(tt);
        e.vtot = DW'(vv);
        e.hst  = DW'(hs);
        e.vst  = DW'(vs);
        return e;
    endfunction

    function automatic mode_t mode_at(input int unsigned i);
        mode_t e;
        case (i)
            0:  e = mk(2, 315, 700, 10, 10,  640,  350,  800,  449, 144, 60);
            1:  e = mk(2, 315, 700, 10, 10,  720,  400,  900,  449, 153, 35);
            2:  e = mk(2, 315, 700, 10, 10,  640,  400,  800,  449, 144, 35);
            3:  e = mk(1, 315, 599, 10, 10,  640,  480,  800,  525, 144, 35);
            4:  e = mk(1, 379, 728, 10, 10,  640,  480,  832,  520, 168, 31);
            5:  e = mk(1, 375, 750, 10, 10,  640,  480,  840,  500, 184, 19);
            6:  e = mk(8, 352, 562, 10, 10,  800,  600, 1024,  625, 200, 24);
            7:  e = mk(8, 379, 603, 10, 10,  800,  600, 1056,  628, 216, 27);
            8:  e = mk(8, 481, 722, 10, 10,  800,  600, 1040,  666, 184, 29);
            9:  e = mk(8, 469, 750, 10, 10,  800,  600, 1056,  625, 240, 24);
            10: e = mk(1, 484, 600, 10, 10, 1024,  768, 1344,  806, 296, 35);
            11: e = mk(1, 565, 701, 10, 10, 1024,  768, 1328,  806, 280, 35);
            12: e = mk(8, 600, 750, 10, 10, 1024,  768, 1312,  800, 272, 31);
            13: e = mk(8, 640, 600, 10, 10, 1280, 1024, 1688, 1066, 360, 41);
            14: e = mk(3, 157, 600, 10, 20,  684,  232,  858,  262, 149, 22);
            15: e = mk(3, 156, 500, 10, 20,  702,  288,  864,  312, 132, 23);
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/vmode_rom.sv
module vmode_rom
    import vmode_pkg::*;
#(
    parameter int N_ENT = NE,
    localparam int IW = $clog2(N_ENT)
) (
    input  logic [IW-1:0] idx,
    output mode_t         ent
);
    always_comb begin
        ent = mode_at(32'(idx));
    end
endmodule

// File: rtl/vmode_eval.sv
module vmode_eval #(
    parameter int FW_P = 12,
    localparam int EW = FW_P + 1
) (
    input  logic [3:0]      pol_mask,
    input  logic [FW_P-1:0] nom_h,
    input  logic [FW_P-1:0] nom_v,
    input  logic [FW_P-1:0] tol_h,
    input  logic [FW_P-1:0] tol_v,
    input  logic [FW_P-1:0] m_h,
    input  logic [FW_P-1:0] m_v,
    input  logic            m_hp,
    input  logic            m_vp,
    output logic            pol_ok,
    output logic            exact,
    output logic [EW-1:0]   err
);
    logic [FW_P-1:0] dh, dv;

    always_comb begin
        dh     = (m_h >= nom_h) ? (m_h - nom_h) : (nom_h - m_h);
        dv     = (m_v >= nom_v) ? (m_v - nom_v) : (nom_v - m_v);
        pol_ok = pol_mask[{m_hp, m_vp}];
        exact  = pol_ok && (dh <= tol_h) && (dv <= tol_v);
        err    = EW'(dh) + EW'(dv);
    end
endmodule

// File: rtl/vmode_watch.sv
module vmode_watch #(
    parameter int FW_P = 12
) (
    input  logic [FW_P-1:0] m_h,
    input  logic            m_hp,
    input  logic            m_vp,
    input  logic [FW_P-1:0] lk_h,
    input  logic [FW_P-1:0] lk_tol,
    input  logic            lk_hp,
    input  logic            lk_vp,
    output logic            signif
);
    logic [FW_P-1:0] drift;
    logic [FW_P:0]   limit;

    always_comb begin
        drift  = (m_h >= lk_h) ? (m_h - lk_h) : (lk_h - m_h);
        limit  = {lk_tol, 1'b0};
        signif = ({1'b0, drift} > limit) || (m_hp != lk_hp) || (m_vp != lk_vp);
    end
endmodule

// File: rtl/vmode_ctrl.sv
module vmode_ctrl
    import vmode_pkg::*;
#(
    parameter int N_ENT = NE,
    parameter int FW_P  = FW,
    parameter int DW_P  = DW,
    localparam int IW   = $clog2(N_ENT),
    localparam int EW   = FW_P + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            meas_valid,
    input  logic [FW_P-1:0] meas_h,
    input  logic [FW_P-1:0] meas_v,
    input  logic            meas_hp,
    input  logic            meas_vp,
    input  logic            signif,
    input  logic            e_pol_ok,
    input  logic            e_exact,
    input  logic [EW-1:0]   e_err,
    input  logic [FW_P-1:0] e_htol,
    input  logic [DW_P-1:0] e_hact,
    input  logic [DW_P-1:0] e_vact,
    input  logic [DW_P-1:0] e_htot,
    input  logic [DW_P-1:0] e_vtot,
    input  logic [DW_P-1:0] e_hst,
    input  logic [DW_P-1:0] e_vst,
    output logic [IW-1:0]   rom_idx,
    output logic [FW_P-1:0] cap_h,
    output logic [FW_P-1:0] cap_v,
    output logic            cap_hp,
    output logic            cap_vp,
    output logic [FW_P-1:0] lock_h,
    output logic [FW_P-1:0] lock_tol,
    output logic            lock_hp,
    output logic            lock_vp,
    output logic            res_valid,
    output logic [IW-1:0]   res_index,
    output logic            res_exact,
    output logic            res_found,
    output logic [DW_P-1:0] res_hact,
    output logic [DW_P-1:0] res_vact,
    output logic [DW_P-1:0] res_htotal,
    output logic [DW_P-1:0] res_vtotal,
    output logic [DW_P-1:0] res_hstart,
    output logic [DW_P-1:0] res_vstart,
    output logic            chg_pulse
);
    localparam logic [IW-1:0] LAST = IW'(N_ENT - 1);

    st_t           state, nxt;
    logic [IW-1:0] scan_idx;
    logic          ex_hit, ap_hit;
    logic [IW-1:0] ex_idx, ap_idx;
    logic [EW-1:0] ap_err;
    logic          capture, relock, found, take_ap;
    logic [IW-1:0] sel_idx;

    always_comb begin
        relock  = (state == ST_LOCK) && meas_valid && signif;
        capture = ((state == ST_IDLE) && meas_valid) || relock;
        found   = ex_hit || ap_hit;
        sel_idx = ex_hit ? ex_idx : (ap_hit ? ap_idx : '0);
        rom_idx = (state == ST_FIN) ? sel_idx : scan_idx;
        take_ap = e_pol_ok && (!ap_hit || (e_err < ap_err));
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (capture) nxt = ST_SCAN;
            ST_SCAN: if (scan_idx == LAST) nxt = ST_FIN;
            ST_FIN:  nxt = found ? ST_LOCK : ST_IDLE;
            ST_LOCK: if (relock) nxt = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_idx <= '0;
            ex_hit <= 1'b0; ex_idx <= '0;
            ap_hit <= 1'b0; ap_idx <= '0; ap_err <= '1;
            cap_h <= '0; cap_v <= '0; cap_hp <= 1'b0; cap_vp <= 1'b0;
            lock_h <= '0; lock_tol <= '0; lock_hp <= 1'b0; lock_vp <= 1'b0;
            res_valid <= 1'b0; res_index <= '0; res_exact <= 1'b0; res_found <= 1'b0;
            res_hact <= '0; res_vact <= '0; res_htotal <= '0; res_vtotal <= '0;
            res_hstart <= '0; res_vstart <= '0;
            chg_pulse <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            chg_pulse <= relock;
            if (capture) begin
                cap_h <= meas_h; cap_v <= meas_v;
                cap_hp <= meas_hp; cap_vp <= meas_vp;
                scan_idx <= '0;
                ex_hit <= 1'b0; ap_hit <= 1'b0; ap_err <= '1;
            end
            unique case (state)
                ST_SCAN: begin
                    scan_idx <= scan_idx + 1'b1;
                    if (e_exact && !ex_hit) begin
                        ex_hit <= 1'b1;
                        ex_idx <= scan_idx;
                    end
                    if (take_ap) begin
                        ap_hit <= 1'b1;
                        ap_idx <= scan_idx;
                        ap_err <= e_err;
                    end
                end
                ST_FIN: begin
                    res_valid <= 1'b1;
                    res_index <= sel_idx;
                    res_exact <= ex_hit;
                    res_found <= found;
                    res_hact   <= found ? e_hact : '0;
                    res_vact   <= found ? e_vact : '0;
                    res_htotal <= found ? e_htot : '0;
                    res_vtotal <= found ? e_vtot : '0;
                    res_hstart <= found ? e_hst  : '0;
                    res_vstart <= found ? e_vst  : '0;
                    lock_h   <= cap_h;
                    lock_tol <= e_htol;
                    lock_hp  <= cap_hp;
                    lock_vp  <= cap_vp;
                end
                default: ;
            endcase
        end
    end

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    assert_chg_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |=> !chg_pulse);
    assert_chg_starts_scan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |-> (state == ST_SCAN) && !res_valid);
    assert_exact_implies_found_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_exact) |-> res_found);
    assert_nomode_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_found) |-> (res_index == '0) && (res_htotal == '0) && (state == ST_IDLE));
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_htotal) && $stable(res_index));
    assert_scan_capture_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SCAN) && (scan_idx != '0)) |-> $stable(cap_h) && $stable(cap_hp));
endmodule

// File: rtl/vmode_matcher.sv
module vmode_matcher
    import vmode_pkg::*;
#(
    parameter int N_ENT = NE,
    parameter int FW_P  = FW,
    parameter int DW_P  = DW,
    localparam int IW   = $clog2(N_ENT),
    localparam int EW   = FW_P + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            meas_valid,
    input  logic [FW_P-1:0] meas_hfreq,
    input  logic [FW_P-1:0] meas_vfreq,
    input  logic            meas_hpol,
    input  logic            meas_vpol,
    output logic            res_valid,
    output logic [IW-1:0]   res_index,
    output logic            res_exact,
    output logic            res_found,
    output logic [DW_P-1:0] res_hact,
    output logic [DW_P-1:0] res_vact,
    output logic [DW_P-1:0] res_htotal,
    output logic [DW_P-1:0] res_vtotal,
    output logic [DW_P-1:0] res_hstart,
    output logic [DW_P-1:0] res_vstart,
    output logic            chg_pulse
);
    mode_t           ent;
    logic [IW-1:0]   rom_idx;
    logic            e_pol_ok, e_exact, signif;
    logic [EW-1:0]   e_err;
    logic [FW_P-1:0] cap_h, cap_v, lock_h, lock_tol;
    logic            cap_hp, cap_vp, lock_hp, lock_vp;

    vmode_rom #(.N_ENT(N_ENT)) u_rom (.idx(rom_idx), .ent(ent));

    vmode_eval #(.FW_P(FW_P)) u_eval (
        .pol_mask(ent.pol_mask), .nom_h(ent.hf), .nom_v(ent.vf),
        .tol_h(ent.htol), .tol_v(ent.vtol),
        .m_h(cap_h), .m_v(cap_v), .m_hp(cap_hp), .m_vp(cap_vp),
        .pol_ok(e_pol_ok), .exact(e_exact), .err(e_err)
    );

    vmode_watch #(.FW_P(FW_P)) u_watch (
        .m_h(meas_hfreq), .m_hp(meas_hpol), .m_vp(meas_vpol),
        .lk_h(lock_h), .lk_tol(lock_tol), .lk_hp(lock_hp), .lk_vp(lock_vp),
        .signif(signif)
    );

    vmode_ctrl #(.N_ENT(N_ENT), .FW_P(FW_P), .DW_P(DW_P)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid),
        .meas_h(meas_hfreq), .meas_v(meas_vfreq), .meas_hp(meas_hpol), .meas_vp(meas_vpol),
        .signif(signif), .e_pol_ok(e_pol_ok), .e_exact(e_exact), .e_err(e_err),
        .e_htol(ent.htol), .e_hact(ent.hact), .e_vact(ent.vact),
        .e_htot(ent.htot), .e_vtot(ent.vtot), .e_hst(ent.hst), .e_vst(ent.vst),
        .rom_idx(rom_idx), .cap_h(cap_h), .cap_v(cap_v), .cap_hp(cap_hp), .cap_vp(cap_vp),
        .lock_h(lock_h), .lock_tol(lock_tol), .lock_hp(lock_hp), .lock_vp(lock_vp),
        .res_valid(res_valid), .res_index(res_index), .res_exact(res_exact),
        .res_found(res_found), .res_hact(res_hact), .res_vact(res_vact),
        .res_htotal(res_htotal), .res_vtotal(res_vtotal),
        .res_hstart(res_hstart), .res_vstart(res_vstart), .chg_pulse(chg_pulse)
    );
endmodule

// File: tb/sim_vmode_matcher.sv
module sim_vmode_matcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_valid = 1'b0;
    logic [11:0] meas_hfreq = '0, meas_vfreq = '0;
    logic        meas_hpol = 1'b0, meas_vpol = 1'b0;
    logic        res_valid, res_exact, res_found, chg_pulse;
    logic [3:0]  res_index;
    logic [11:0] res_hact, res_vact, res_htotal, res_vtotal, res_hstart, res_vstart;

    always #4 clk = ~clk;

    vmode_matcher u0 (.*);

    // mask, hf, vf, htol, vtol, hact, vact, htot, vtot, hst, vst
    int tab [16][11] = '{
        '{2,315,700,10,10, 640, 350, 800, 449,144,60},
        '{2,315,700,10,10, 720, 400, 900, 449,153,35},
        '{2,315,700,10,10, 640, 400, 800, 449,144,35},
        '{1,315,599,10,10, 640, 480, 800, 525,144,35},
        '{1,379,728,10,10, 640, 480, 832, 520,168,31},
        '{1,375,750,10,10, 640, 480, 840, 500,184,19},
        '{8,352,562,10,10, 800, 600,1024, 625,200,24},
        '{8,379,603,10,10, 800, 600,1056, 628,216,27},
        '{8,481,722,10,10, 800, 600,1040, 666,184,29},
        '{8,469,750,10,10, 800, 600,1056, 625,240,24},
        '{1,484,600,10,10,1024, 768,1344, 806,296,35},
        '{1,565,701,10,10,1024, 768,1328, 806,280,35},
        '{8,600,750,10,10,1024, 768,1312, 800,272,31},
        '{8,640,600,10,10,1280,1024,1688,1066,360,41},
        '{3,157,600,10,20, 684, 232, 858, 262,149,22},
        '{3,156,500,10,20, 702, 288, 864, 312,132,23}
    };

    int errors = 0, checks = 0;
    bit done = 0;
    string tag = "R1";

    // model state: 0 idle, 1 scan, 2 fin, 3 lock
    int  mst = 0, mcnt = 0;
    int  ch = 0, cv = 0; bit chp = 0, cvp = 0;
    int  lk_h = 0, lk_tol = 0; bit lk_hp = 0, lk_vp = 0;
    bit  exp_valid = 0, exp_chg = 0, exp_exact = 0, exp_found = 0;
    int  exp_idx = 0;
    int  exp_f [6] = '{0,0,0,0,0,0};

    function automatic int iabs(int a);
        return (a < 0) ? -a : a;
    endfunction

    function automatic void ref_match(input int h, input int v, input bit hp, input bit vp,
                                      output int idx, output bit ex, output bit fd);
        int best, ai, dh, dv;
        bit ah;
        best = 1 << 30; ai = 0; ah = 0; ex = 0; idx = 0;
        for (int i = 0; i < 16; i++) begin
            if (((tab[i][0] >> (2*hp + vp)) & 1) == 1) begin
                dh = iabs(h - tab[i][1]);
                dv = iabs(v - tab[i][2]);
                if (!ex && dh <= tab[i][3] && dv <= tab[i][4]) begin
                    ex = 1; idx = i;
                end
                if (dh + dv < best) begin
                    best = dh + dv; ai = i; ah = 1;
                end
            end
        end
        if (!ex) idx = ah ? ai : 0;
        fd = ex | ah;
    endfunction

    always @(posedge clk) begin
        int ri; bit rex, rfd;
        exp_valid = 0;
        exp_chg = 0;
        if (!rst_n) begin
            mst = 0; mcnt = 0; exp_idx = 0; exp_exact = 0; exp_found = 0;
            for (int k = 0; k < 6; k++) exp_f[k] = 0;
        end else begin
            case (mst)
                0: if (meas_valid) begin
                    ch = meas_hfreq; cv = meas_vfreq; chp = meas_hpol; cvp = meas_vpol;
                    mcnt = 0; mst = 1;
                end
                1: begin
                    mcnt++;
                    if (mcnt == 16) mst = 2;
                end
                2: begin
                    ref_match(ch, cv, chp, cvp, ri, rex, rfd);
                    exp_valid = 1; exp_idx = ri; exp_exact = rex; exp_found = rfd;
                    for (int k = 0; k < 6; k++) exp_f[k] = rfd ? tab[ri][5+k] : 0;
                    lk_h = ch; lk_tol = tab[ri][3]; lk_hp = chp; lk_vp = cvp;
                    mst = rfd ? 3 : 0;
                end
                default: if (meas_valid &&
                             (iabs(meas_hfreq - lk_h) > 2*lk_tol ||
                              meas_hpol != lk_hp || meas_vpol != lk_vp)) begin
                    exp_chg = 1;
                    ch = meas_hfreq; cv = meas_vfreq; chp = meas_hpol; cvp = meas_vpol;
                    mcnt = 0; mst = 1;
                end
            endcase
        end
    end

    task automatic chk(input string t, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", t, what, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6", "res_valid", res_valid, exp_valid);
            chk("R9", "chg_pulse", chg_pulse, exp_chg);
            chk(tag, "res_index", res_index, exp_idx);
            chk(tag, "res_exact", res_exact, exp_exact);
            chk(tag, "res_found", res_found, exp_found);
            chk(tag, "res_hact", res_hact, exp_f[0]);
            chk(tag, "res_vact", res_vact, exp_f[1]);
            chk(tag, "res_htotal", res_htotal, exp_f[2]);
            chk(tag, "res_vtotal", res_vtotal, exp_f[3]);
            chk(tag, "res_hstart", res_hstart, exp_f[4]);
            chk(tag, "res_vstart", res_vstart, exp_f[5]);
        end
    end

    task automatic strobe(input int h, input int v, input bit hp, input bit vp);
        @(negedge clk);
        meas_hfreq = 12'(h); meas_vfreq = 12'(v);
        meas_hpol = hp; meas_vpol = vp; meas_valid = 1'b1;
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_result(input string t, input int idx, input bit ex, input bit fd);
        chk(t, "directed index", res_index, idx);
        chk(t, "directed exact", res_exact, ex);
        chk(t, "directed found", res_found, fd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs zero while in reset
        chk("R1", "valid in reset", res_valid, 0);
        chk("R1", "htotal in reset", res_htotal, 0);
        chk("R1", "chg in reset", chg_pulse, 0);
        rst_n = 1'b1;
        idle(3);

        tag = "R2"; strobe(315, 599, 0, 0); idle(20);       // exact entry 3
        expect_result("R2", 3, 1, 1);
        tag = "R8"; strobe(335, 599, 0, 0); idle(25);        // drift exactly 2*tol: ignored
        expect_result("R8", 3, 1, 1);
        chk("R8", "htotal kept", res_htotal, 800);
        tag = "R9"; strobe(379, 728, 0, 0); idle(3);          // big jump, relock
        tag = "R7"; strobe(600, 750, 1, 1); idle(20);         // during scan: ignored
        expect_result("R7", 4, 1, 1);
        tag = "R9"; strobe(379, 603, 1, 1); idle(20);         // polarity flip only
        expect_result("R9", 7, 1, 1);
        tag = "R3"; strobe(316, 700, 0, 1); idle(20);         // three-way tie
        expect_result("R3", 0, 1, 1);
        tag = "R4"; strobe(500, 650, 1, 1); idle(20);         // nearest: entry 8
        expect_result("R4", 8, 0, 1);
        tag = "R5"; strobe(500, 600, 1, 0); idle(20);         // no accepting entry
        expect_result("R5", 0, 0, 0);
        tag = "R10"; strobe(167, 620, 0, 0); idle(20);        // tolerance edges, entry 14
        expect_result("R10", 14, 1, 1);
        tag = "R8"; strobe(147, 600, 0, 0); idle(25);         // drift = 20, ignored
        expect_result("R8", 14, 1, 1);
        tag = "R4"; strobe(146, 600, 0, 0); idle(20);         // drift = 21, relock approx
        expect_result("R4", 14, 0, 1);
        idle(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog R6 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule